// File: doc/BRIEF.md
# Link Training State Controller

This block sequences one serial link from power-up through training into normal operation. It also handles the low-power, retraining and special states that can follow. Outside logic reports the link events as single-cycle strobes: a far-end receiver was found, electrical idle was broken, symbol lock is present, a training-set exchange step completed, recovery failed. Requests come in the same way: retrain, standby entry and exit, low power, deep power-down, wake, disable and enable, in-band reset, loopback entry and exit. The block answers with a numeric state code, a link-up flag and requests for the transmitter to send first-phase training sets, second-phase training sets or electrical-idle sets.

One counter measures how long the block has stayed in the current state. It restarts on every state change. Three parameters, all given in clock cycles, set the limits: a quiet-wait limit, a long training limit and a short training limit. When a training state runs past its limit, the link falls back to the quiet detect state. An event that moves the block forward in the same cycle that its limit expires takes precedence over the fallback.

Top module: `link_trainer`

## Requirements
- R1: While reset is low the state code is 0 (detect-quiet) and link_up, tx_ts1, tx_ts2 and tx_eidle are all 0.
- R2: Detect-quiet (0) moves to detect-active (1) when idle_break is high or after QUIET_TO cycles in the state. Detect-active moves to polling-active (2) if rcv_det is high, otherwise back to 0.
- R3: Polling-active (2) moves to polling-config (3) on ts_ok together with sym_lock. ts_ok alone leaves it in 2. Polling-config moves to config-width (4) on ts_ok. Either polling state returns to 0 after LONG_TO cycles without progress.
- R4: Configuration steps 4 → 5 → 6 → 7 → L0 (8), one step per ts_ok. States 4 to 6 fall back to 0 after LONG_TO cycles and state 7 after SHORT_TO cycles. A ts_ok in the cycle the limit expires still advances.
- R5: In L0, requests are served in this priority: hot_rst_req → hot reset (17), disable_req → disabled (15), retrain_req → recovery-lock (9), loop_req → loopback (16), d3_req → deep power-down (14), pm_req → low power (13), aspm_req → standby (12).
- R6: Recovery-lock (9) moves to recovery-speed (10) on ts_ok with sym_lock. State 10 moves to recovery-idle (11) on ts_ok, and state 11 moves to L0 on ts_ok. rx_fail in any of 9 to 11 goes to disabled (15), even when ts_ok is also high. Timeouts to 0 are LONG_TO for state 9 and SHORT_TO for states 10 and 11.
- R7: Standby (12) returns straight to L0 on aspm_exit. Low power (13) goes to recovery-lock (9) on wake.
- R8: Deep power-down (14) goes to 0 on wake. Disabled (15) goes to 0 on enable.
- R9: Hot reset (17) stays for SHORT_TO cycles and then goes to 0. Loopback (16) stays until loop_done and then goes to 0.
- R10: link_up is 1 exactly in states 8, 12 and 13.
- R11: tx_ts1 is 1 exactly in states 2 and 9. tx_ts2 is 1 exactly in states 3 and 6. tx_eidle is 1 exactly in states 12, 13 and 14.
- R12: An input that has no transition defined for the current state leaves the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rcv_det | input | 1 | Far-end receiver found |
| idle_break | input | 1 | Electrical idle exit seen |
| sym_lock | input | 1 | Symbol lock present |
| ts_ok | input | 1 | Training-set exchange step complete |
| rx_fail | input | 1 | Recovery failure |
| retrain_req | input | 1 | Retrain request |
| aspm_req | input | 1 | Standby entry request |
| aspm_exit | input | 1 | Standby exit |
| pm_req | input | 1 | Low-power entry request |
| d3_req | input | 1 | Deep power-down request |
| wake | input | 1 | Wake event |
| disable_req | input | 1 | Link disable request |
| enable | input | 1 | Link re-enable |
| hot_rst_req | input | 1 | In-band reset request |
| loop_req | input | 1 | Loopback entry request |
| loop_done | input | 1 | Loopback exit |
| state | output | 5 | Current state code |
| link_up | output | 1 | Link usable |
| tx_ts1 | output | 1 | Send first-phase training sets |
| tx_ts2 | output | 1 | Send second-phase training sets |
| tx_eidle | output | 1 | Send electrical-idle sets |

## Verification
Two kinds of collision can land on the same clock edge, and the bench drives both. In the first, a progress event (ts_ok) arrives in the very cycle that a state's timeout expires. The bench sits idle in config-idle for SHORT_TO-1 cycles and then pulses ts_ok. The expected next state is L0, not detect-quiet. In the second, several events compete for the same edge: every L0 request is raised at once, then the highest one is removed, and this repeats down the priority list. Also, rx_fail is raised together with sym_lock and ts_ok in recovery-lock. In each case the scoreboard expects only the winner's next state.

// File: rtl/link_trainer.sv
module link_trainer #(
  parameter int QUIET_TO = 12,
  parameter int LONG_TO  = 24,
  parameter int SHORT_TO = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rcv_det,
  input  logic       idle_break,
  input  logic       sym_lock,
  input  logic       ts_ok,
  input  logic       rx_fail,
  input  logic       retrain_req,
  input  logic       aspm_req,
  input  logic       aspm_exit,
  input  logic       pm_req,
  input  logic       d3_req,
  input  logic       wake,
  input  logic       disable_req,
  input  logic       enable,
  input  logic       hot_rst_req,
  input  logic       loop_req,
  input  logic       loop_done,
  output logic [4:0] state,
  output logic       link_up,
  output logic       tx_ts1,
  output logic       tx_ts2,
  output logic       tx_eidle
);
  localparam int MX1 = (QUIET_TO > LONG_TO) ? QUIET_TO : LONG_TO;
  localparam int MX  = (MX1 > SHORT_TO) ? MX1 : SHORT_TO;
  localparam int TW  = $clog2(MX + 1);

  typedef enum logic [4:0] {
    DET_QUIET = 5'd0,  DET_ACT  = 5'd1,  POL_ACT  = 5'd2,  POL_CFG  = 5'd3,
    CFG_WIDTH = 5'd4,  CFG_LANE = 5'd5,  CFG_DONE = 5'd6,  CFG_IDLE = 5'd7,
    L0        = 5'd8,  REC_LOCK = 5'd9,  REC_SPD  = 5'd10, REC_IDLE = 5'd11,
    STBY      = 5'd12, LOWP     = 5'd13, DEEP     = 5'd14, DISABLED = 5'd15,
    LOOPBK    = 5'd16, HOTRST   = 5'd17
  } st_t;

  st_t cur, nxt;
  logic [TW-1:0] tmr;

  wire exp_q = tmr == TW'(QUIET_TO - 1);
  wire exp_l = tmr == TW'(LONG_TO - 1);
  wire exp_s = tmr == TW'(SHORT_TO - 1);

  always_comb begin
    nxt = cur;
    case (cur)
      DET_QUIET: if (idle_break || exp_q) nxt = DET_ACT;
      DET_ACT:   nxt = rcv_det ? POL_ACT : DET_QUIET;
      POL_ACT:   if (ts_ok && sym_lock) nxt = POL_CFG;
                 else if (exp_l) nxt = DET_QUIET;
      POL_CFG:   if (ts_ok) nxt = CFG_WIDTH; else if (exp_l) nxt = DET_QUIET;
      CFG_WIDTH: if (ts_ok) nxt = CFG_LANE;  else if (exp_l) nxt = DET_QUIET;
      CFG_LANE:  if (ts_ok) nxt = CFG_DONE;  else if (exp_l) nxt = DET_QUIET;
      CFG_DONE:  if (ts_ok) nxt = CFG_IDLE;  else if (exp_l) nxt = DET_QUIET;
      CFG_IDLE:  if (ts_ok) nxt = L0;        else if (exp_s) nxt = DET_QUIET;
      L0: begin
        if (hot_rst_req)      nxt = HOTRST;
        else if (disable_req) nxt = DISABLED;
        else if (retrain_req) nxt = REC_LOCK;
        else if (loop_req)    nxt = LOOPBK;
        else if (d3_req)      nxt = DEEP;
        else if (pm_req)      nxt = LOWP;
        else if (aspm_req)    nxt = STBY;
      end
      REC_LOCK:  if (rx_fail) nxt = DISABLED;
                 else if (ts_ok && sym_lock) nxt = REC_SPD;
                 else if (exp_l) nxt = DET_QUIET;
      REC_SPD:   if (rx_fail) nxt = DISABLED;
                 else if (ts_ok) nxt = REC_IDLE;
                 else if (exp_s) nxt = DET_QUIET;
      REC_IDLE:  if (rx_fail) nxt = DISABLED;
                 else if (ts_ok) nxt = L0;
                 else if (exp_s) nxt = DET_QUIET;
      STBY:      if (aspm_exit) nxt = L0;
      LOWP:      if (wake) nxt = REC_LOCK;
      DEEP:      if (wake) nxt = DET_QUIET;
      DISABLED:  if (enable) nxt = DET_QUIET;
      LOOPBK:    if (loop_done) nxt = DET_QUIET;
      HOTRST:    if (exp_s) nxt = DET_QUIET;
      default:   nxt = DET_QUIET;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= DET_QUIET;
      tmr <= '0;
    end else begin
      cur <= nxt;
      if (nxt != cur)    tmr <= '0;
      else if (tmr != '1) tmr <= tmr + 1'b1;
    end
  end

  assign state    = cur;
  assign link_up  = (cur == L0) || (cur == STBY) || (cur == LOWP);
  assign tx_ts1   = (cur == POL_ACT) || (cur == REC_LOCK);
  assign tx_ts2   = (cur == POL_CFG) || (cur == CFG_DONE);
  assign tx_eidle = (cur == STBY) || (cur == LOWP) || (cur == DEEP);
endmodule

// File: rtl/link_trainer_chk.sv
module link_trainer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ts_ok,
  input logic       rx_fail,
  input logic       aspm_exit,
  input logic       wake,
  input logic       enable,
  input logic [4:0] state,
  input logic       link_up,
  input logic       tx_ts1,
  input logic       tx_ts2,
  input logic       tx_eidle
);
  p_reset_state_r1: assert property (@(posedge clk) !rst_n |=> state == 5'd0);

  p_cfg_to_l0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 5'd7 && ts_ok) |=> state == 5'd8);

  p_fail_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state >= 5'd9 && state <= 5'd11 && rx_fail) |=> state == 5'd15);

  p_stby_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 5'd12 && aspm_exit) |=> state == 5'd8);

  p_lowp_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 5'd13 && wake) |=> state == 5'd9);

  p_deep_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 5'd14 && wake) |=> state == 5'd0);

  p_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 5'd15 && enable) |=> state == 5'd0);

  p_linkup_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_up) |-> state == 5'd8);

  p_tx_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_ts1, tx_ts2, tx_eidle}));
endmodule

bind link_trainer link_trainer_chk u_chk (.*);

// File: tb/sim_link_trainer.sv
module sim_link_trainer;
  localparam int QT = 12, LT = 24, ST = 2;
  localparam logic [15:0] RD = 16'h0001, IB = 16'h0002, SL = 16'h0004, TS = 16'h0008,
    RF = 16'h0010, RT = 16'h0020, AR = 16'h0040, AX = 16'h0080, PM = 16'h0100,
    D3 = 16'h0200, WK = 16'h0400, DR = 16'h0800, EN = 16'h1000, HR = 16'h2000,
    LR = 16'h4000, LD = 16'h8000;

  logic clk = 0, rst_n = 0;
  logic [15:0] stim = '0;
  logic [4:0] state;
  logic link_up, tx_ts1, tx_ts2, tx_eidle;
  int total = 0, bad = 0;
  int q_st[$];
  string q_tag[$];

  always #4 clk = ~clk;

  link_trainer #(.QUIET_TO(QT), .LONG_TO(LT), .SHORT_TO(ST)) u0 (
    .clk(clk), .rst_n(rst_n), .rcv_det(stim[0]), .idle_break(stim[1]),
    .sym_lock(stim[2]), .ts_ok(stim[3]), .rx_fail(stim[4]), .retrain_req(stim[5]),
    .aspm_req(stim[6]), .aspm_exit(stim[7]), .pm_req(stim[8]), .d3_req(stim[9]),
    .wake(stim[10]), .disable_req(stim[11]), .enable(stim[12]), .hot_rst_req(stim[13]),
    .loop_req(stim[14]), .loop_done(stim[15]), .state(state), .link_up(link_up),
    .tx_ts1(tx_ts1), .tx_ts2(tx_ts2), .tx_eidle(tx_eidle));

  function automatic logic [8:0] expect_out(int s);
    logic lu, t1, t2, te;
    lu = (s == 8) || (s == 12) || (s == 13);
    t1 = (s == 2) || (s == 9);
    t2 = (s == 3) || (s == 6);
    te = (s == 12) || (s == 13) || (s == 14);
    return {5'(s), lu, t1, t2, te};
  endfunction

  task automatic go(logic [15:0] v, int exp_s, string tag);
    stim = v;
    q_st.push_back(exp_s);
    q_tag.push_back(tag);
    @(negedge clk);
  endtask

  task automatic train_up();
    go(IB, 1, "R2 break");
    go(RD, 2, "R2 detect");
    go(TS | SL, 3, "R3 lock");
    go(TS, 4, "R3 cfg");
    go(TS, 5, "R4 lane");
    go(TS, 6, "R4 done");
    go(TS, 7, "R4 idle");
    go(0, 7, "R4 wait");
    go(TS, 8, "R4 event at expiry");
  endtask

  always begin
    @(posedge clk);
    #2;
    if (q_st.size() > 0) begin
      int es;
      string tg;
      logic [8:0] act, ex;
      es = q_st.pop_front();
      tg = q_tag.pop_front();
      ex = expect_out(es);
      act = {state, link_up, tx_ts1, tx_ts2, tx_eidle};
      total++;
      if (act !== ex) begin
        bad++;
        $display("FAIL %s (R10 R11 outputs): got st=%0d flags=%b exp st=%0d flags=%b",
                 tg, act[8:4], act[3:0], ex[8:4], ex[3:0]);
      end
    end
  end

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog: got hung run exp completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if ({state, link_up, tx_ts1, tx_ts2, tx_eidle} !== 9'd0) begin
      bad++;
      $display("FAIL R1 reset: got %b exp %b", {state, link_up, tx_ts1, tx_ts2, tx_eidle}, 9'd0);
    end
    rst_n = 1;
    for (int i = 0; i < QT - 1; i++) go(0, 0, "R2 quiet wait");
    go(0, 1, "R2 quiet timeout");
    go(0, 0, "R2 no receiver");
    go(IB, 1, "R2 idle break");
    go(RD, 2, "R2 receiver");
    go(TS, 2, "R3 ts without lock");
    for (int i = 0; i < LT - 2; i++) go(0, 2, "R3 poll wait");
    go(0, 0, "R3 poll timeout");
    go(IB, 1, "R2 break");
    go(RD, 2, "R2 receiver");
    go(TS | SL, 3, "R3 to config");
    go(TS, 4, "R3 width");
    go(TS, 5, "R4 lane");
    go(TS, 6, "R4 complete");
    go(TS, 7, "R4 idle");
    go(0, 7, "R4 idle wait");
    go(0, 0, "R4 idle timeout");
    train_up();
    go(WK | TS | AX | EN | LD, 8, "R12 ignored in L0");
    go(AR, 12, "R5 standby");
    go(TS | WK | RT, 12, "R12 ignored in standby");
    go(AX, 8, "R7 standby exit");
    go(PM, 13, "R5 low power");
    go(WK, 9, "R7 wake via recovery");
    go(TS, 9, "R6 no lock");
    go(TS | SL, 10, "R6 speed");
    go(TS, 11, "R6 rec idle");
    go(TS, 8, "R6 back to L0");
    go(HR | DR | RT | LR | D3 | PM | AR, 17, "R5 hot reset first");
    go(0, 17, "R9 hot reset hold");
    go(0, 0, "R9 hot reset done");
    train_up();
    go(DR | RT | LR | D3 | PM | AR, 15, "R5 disable second");
    go(WK | TS, 15, "R12 ignored in disabled");
    go(EN, 0, "R8 enable");
    train_up();
    go(RT | LR | D3 | PM | AR, 9, "R5 retrain third");
    go(RF | TS | SL, 15, "R6 fail beats progress");
    go(EN, 0, "R8 enable");
    train_up();
    go(LR | D3 | PM | AR, 16, "R5 loopback fourth");
    go(TS | WK, 16, "R9 loopback hold");
    go(LD, 0, "R9 loopback exit");
    train_up();
    go(D3 | PM | AR, 14, "R5 deep fifth");
    go(TS, 14, "R12 ignored in deep");
    go(WK, 0, "R8 deep wake");
    train_up();
    go(PM | AR, 13, "R5 low power sixth");
    go(WK, 9, "R7 wake");
    go(TS | SL, 10, "R6 speed");
    go(0, 10, "R6 speed wait");
    go(0, 0, "R6 speed timeout");
    train_up();
    go(RT, 9, "R5 retrain");
    for (int i = 0; i < LT - 1; i++) go(0, 9, "R6 lock wait");
    go(0, 0, "R6 lock timeout");
    @(posedge clk);
    #3;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule